// File: doc/BRIEF.md
# Serial Flash Page-Program Front End

This block is the serial-slave command engine of a flash device model. While chip select is low it shifts in bytes, most significant bit first, on rising edges of the serial clock, which it samples with the system clock. It recognises two commands. The first is a four-byte whole-array wipe. The second is a page program that goes through one of two on-chip SRAM page buffers. Both commands are carried out only once chip select returns high.

A program command takes an opcode that picks the buffer, then a 24-bit address and then data. The address gives a target page and a start position in the buffer. Data bytes fill the buffer from that position onward, and the pointer wraps back to the first location. When the frame closes cleanly, a self-timed cycle begins. It first sets the target page of a small register-based page array to all ones, then copies the whole buffer into that page. The `ready` output is low for the entire cycle.

A write-protect input guards a parameter-chosen set of pages. Its level is sampled when a cycle would start, so a change in the middle of a cycle takes effect only for later commands. A combinational peek port reads the page array so that its contents can be observed.

Top module: `flash_prog_engine`

## Requirements
- R1: Bytes are assembled MSB first from `spi_mosi` on `spi_sclk` rising edges while `spi_cs_n` is low. A rise of `spi_cs_n` after a bit count that is not a multiple of eight aborts the command: no cycle starts and `ready` stays high. Every complete byte received before the abort still takes effect.
- R2: A whole-array wipe starts only for a frame of exactly four bytes C7h, 94h, 80h, 9Ah in that order. It keeps `ready` low for WIPE_CYC cycles and then leaves every page at FFh. A mismatched byte or any extra byte cancels the wipe.
- R3: Opcode 82h writes data into buffer 0 and opcode 85h writes into buffer 1. Any other first byte makes the whole frame have no effect.
- R4: Three address bytes must follow the program opcode. A frame that closes with fewer than three address bytes starts no cycle.
- R5: In standard mode (BINARY_PAGES=0) address bits 23:11 are the page field and bits 10:0 are the offset field. In binary mode, bits 22:10 are the page field and bits 9:0 are the offset field. The page used is the page field mod NPAGES, and the start position is the offset field mod BUF_BYTES.
- R6: Data bytes go to consecutive buffer positions, and the position after BUF_BYTES-1 is 0.
- R7: After a clean program frame, `ready` falls at the second rising clock edge at which `spi_cs_n` is sampled high. It stays low for ERASE_CYC+PROG_CYC cycles. The target page reads FFh once ERASE_CYC of those cycles are done, and it holds the selected buffer contents when `ready` rises. After reset `ready` is 1 and the array reads 00h.
- R8: Any frame in which a byte arrives while `ready` is low is ignored. It changes neither buffer nor the array, and it starts no cycle.
- R9: While `wp` is 1, a program aimed at a page whose PROT_MASK bit is set, or a wipe when any PROT_MASK bit is set, starts no cycle and changes nothing. `wp` is sampled only at the start of a cycle.
- R10: `peek_byte` shows the array byte at page `peek_page` and offset `peek_ofs` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, already synchronous to clk |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| wp | input | 1 | Write protect, high guards masked pages |
| ready | output | 1 | High when no internal cycle runs |
| peek_page | input | $clog2(NPAGES) | Array page to observe |
| peek_ofs | input | $clog2(BUF_BYTES) | Byte within the page to observe |
| peek_byte | output | 8 | Observed array byte |

## Verification
The bench builds the block with a 12-byte buffer and four pages, so offsets are not a power of two. This makes the modulo start position and the wrap after the last location reachable with short frames. With ERASE_CYC=20 and PROG_CYC=30, a busy window is longer than one serial byte, so a second command can be driven entirely inside a running cycle. Page 1 is the only guarded page, so protected and unprotected targets are compared side by side. Standard address mode is the one built.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  typedef enum logic [1:0] {OP_NONE, OP_WIPE, OP_PROG} op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_COPY, PH_WIPE} phase_e;

  localparam logic [7:0] OPC_BUF_A = 8'h82;
  localparam logic [7:0] OPC_BUF_B = 8'h85;

  // expected byte of the wipe key at frame position idx
  function automatic logic [7:0] wipe_key(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'hC7;
      3'd1:    return 8'h94;
      3'd2:    return 8'h80;
      3'd3:    return 8'h9A;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [12:0] page_field(input logic [23:0] a, input bit binary);
    return binary ? a[22:10] : a[23:11];
  endfunction

  function automatic int unsigned page_index(input logic [23:0] a, input bit binary,
                                             input int unsigned npages);
    return 32'(page_field(a, binary)) % npages;
  endfunction

  function automatic int unsigned start_offset(input logic [23:0] a, input bit binary,
                                               input int unsigned nbytes);
    int unsigned f;
    f = binary ? 32'(a[9:0]) : 32'(a[10:0]);
    return f % nbytes;
  endfunction

  function automatic int unsigned next_ptr(input int unsigned cur, input int unsigned nbytes);
    return (cur + 1 == nbytes) ? 0 : cur + 1;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ffe_spi_rx.sv
module ffe_spi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       frame_start,
  output logic       frame_end,
  output logic       frame_aligned
);
  logic       sclk_q;
  logic       cs_q;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       sck_rise;

  assign sck_rise      = sclk & ~sclk_q & ~cs_n;
  assign frame_start   = cs_q & ~cs_n;
  assign frame_end     = cs_n & ~cs_q;
  assign frame_aligned = (bit_cnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      bit_cnt    <= 3'd0;
      shreg      <= 7'd0;
      byte_valid <= 1'b0;
      byte_data  <= 8'd0;
    end else begin
      sclk_q     <= sclk;
      cs_q       <= cs_n;
      byte_valid <= 1'b0;
      if (cs_n) begin
        bit_cnt <= 3'd0;
      end else if (sck_rise) begin
        shreg   <= {shreg[5:0], mosi};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_valid <= 1'b1;
          byte_data  <= {shreg, mosi};
        end
      end
    end
  end

  // R1: a byte is only delivered out of a frame that was open
  assert_byte_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(!cs_n));

endmodule

// File: rtl/ffe_cmd_decode.sv
module ffe_cmd_decode import flash_fe_pkg::*; #(
  parameter int BUF_BYTES    = 12,
  parameter int NPAGES       = 4,
  parameter int BINARY_PAGES = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         byte_valid,
  input  logic [7:0]                   byte_data,
  input  logic                         frame_start,
  input  logic                         frame_end,
  input  logic                         frame_aligned,
  input  logic                         busy,
  output logic                         buf_we,
  output logic                         buf_sel,
  output logic [$clog2(BUF_BYTES)-1:0] buf_ptr,
  output logic [7:0]                   buf_wdata,
  output logic                         launch_prog,
  output logic                         launch_wipe,
  output logic [$clog2(NPAGES)-1:0]    prog_page,
  output logic                         prog_sel
);
  localparam int  PTR_W  = $clog2(BUF_BYTES);
  localparam int  PG_W   = $clog2(NPAGES);
  localparam bit  BINMOD = (BINARY_PAGES != 0);

  op_e              op;
  logic             sel;
  logic [2:0]       idx;
  logic             ce_ok;
  logic [23:0]      addr;
  logic [PTR_W-1:0] ptr;
  logic             void_q;
  logic             short_addr;

  assign buf_we     = byte_valid && (op == OP_PROG) && (idx >= 3'd4) && !void_q && !busy;
  assign buf_sel    = sel;
  assign buf_ptr    = ptr;
  assign buf_wdata  = byte_data;
  assign prog_page  = PG_W'(page_index(addr, BINMOD, NPAGES));
  assign prog_sel   = sel;
  assign short_addr = (op == OP_PROG) && (idx < 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op          <= OP_NONE;
      sel         <= 1'b0;
      idx         <= 3'd0;
      ce_ok       <= 1'b0;
      addr        <= 24'd0;
      ptr         <= '0;
      void_q      <= 1'b0;
      launch_prog <= 1'b0;
      launch_wipe <= 1'b0;
    end else begin
      launch_prog <= 1'b0;
      launch_wipe <= 1'b0;
      if (frame_start) begin
        op     <= OP_NONE;
        idx    <= 3'd0;
        ce_ok  <= 1'b0;
        void_q <= 1'b0;
      end else if (byte_valid) begin
        if (busy) void_q <= 1'b1;
        if (idx != 3'd7) idx <= idx + 3'd1;
        if (idx == 3'd0) begin
          ce_ok <= (byte_data == wipe_key(3'd0));
          sel   <= (byte_data == OPC_BUF_B);
          if (byte_data == wipe_key(3'd0))
            op <= OP_WIPE;
          else if (byte_data == OPC_BUF_A || byte_data == OPC_BUF_B)
            op <= OP_PROG;
          else
            op <= OP_NONE;
        end else if (idx <= 3'd3) begin
          ce_ok <= ce_ok && (byte_data == wipe_key(idx));
          addr  <= {addr[15:0], byte_data};
          if (idx == 3'd3)
            ptr <= PTR_W'(start_offset({addr[15:0], byte_data}, BINMOD, BUF_BYTES));
        end else begin
          ce_ok <= 1'b0;
          if (buf_we) ptr <= PTR_W'(next_ptr(32'(ptr), BUF_BYTES));
        end
      end
      if (frame_end && frame_aligned && !void_q && !busy) begin
        launch_wipe <= (op == OP_WIPE) && ce_ok && (idx == 3'd4);
        launch_prog <= (op == OP_PROG) && (idx >= 3'd4);
      end
    end
  end

  // R6: the write position never leaves the buffer after a data byte
  assert_ptr_in_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (32'(ptr) < BUF_BYTES));

  // R1: a frame closed mid-byte launches nothing
  assert_abort_midbyte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_aligned) |=> !(launch_prog || launch_wipe));

  // R4: a program frame short of its address launches nothing
  assert_short_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && short_addr) |=> !launch_prog);

endmodule

// File: rtl/ffe_page_buffers.sv
module ffe_page_buffers #(
  parameter int BUF_BYTES = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic                         sel,
  input  logic [$clog2(BUF_BYTES)-1:0] ptr,
  input  logic [7:0]                   wdata,
  output logic [7:0]                   rows [2][BUF_BYTES]
);
  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [7:0] store [BUF_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < BUF_BYTES; i++) store[i] <= 8'd0;
      end else if (we && (sel == 1'(b))) begin
        store[ptr] <= wdata;
      end
    end

    assign rows[b] = store;
  end

endmodule

// File: rtl/ffe_cycle_seq.sv
module ffe_cycle_seq import flash_fe_pkg::*; #(
  parameter int                NPAGES    = 4,
  parameter int                BUF_BYTES = 12,
  parameter int                ERASE_CYC = 20,
  parameter int                PROG_CYC  = 30,
  parameter int                WIPE_CYC  = 40,
  parameter logic [NPAGES-1:0] PROT_MASK = NPAGES'(2)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         launch_prog,
  input  logic                         launch_wipe,
  input  logic [$clog2(NPAGES)-1:0]    prog_page,
  input  logic                         prog_sel,
  input  logic [7:0]                   rows [2][BUF_BYTES],
  input  logic                         wp,
  input  logic [$clog2(NPAGES)-1:0]    peek_page,
  input  logic [$clog2(BUF_BYTES)-1:0] peek_ofs,
  output logic                         busy,
  output logic [7:0]                   peek_byte
);
  localparam int PG_W = $clog2(NPAGES);
  localparam int MAXC = max3(ERASE_CYC, PROG_CYC, WIPE_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  phase_e          phase;
  logic [CW-1:0]   cnt;
  logic [PG_W-1:0] tgt_page;
  logic            tgt_sel;
  logic [7:0]      mem [NPAGES][BUF_BYTES];
  logic            guard_page;
  logic            guard_all;
  logic            accept_prog;
  logic            accept_wipe;
  logic            step_done;

  assign guard_page  = wp & PROT_MASK[prog_page];
  assign guard_all   = wp & (|PROT_MASK);
  assign busy        = (phase != PH_IDLE);
  assign accept_prog = launch_prog & ~busy & ~guard_page;
  assign accept_wipe = launch_wipe & ~busy & ~guard_all;
  assign step_done   = (cnt == '0);
  assign peek_byte   = (32'(peek_ofs) < BUF_BYTES) ? mem[peek_page][peek_ofs] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      tgt_page <= '0;
      tgt_sel  <= 1'b0;
      for (int p = 0; p < NPAGES; p++)
        for (int o = 0; o < BUF_BYTES; o++) mem[p][o] <= 8'h00;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept_prog) begin
            phase    <= PH_ERASE;
            cnt      <= CW'(ERASE_CYC - 1);
            tgt_page <= prog_page;
            tgt_sel  <= prog_sel;
          end else if (accept_wipe) begin
            phase <= PH_WIPE;
            cnt   <= CW'(WIPE_CYC - 1);
          end
        end
        PH_ERASE: begin
          if (step_done) begin
            for (int o = 0; o < BUF_BYTES; o++) mem[tgt_page][o] <= 8'hFF;
            phase <= PH_COPY;
            cnt   <= CW'(PROG_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_COPY: begin
          if (step_done) begin
            for (int o = 0; o < BUF_BYTES; o++) mem[tgt_page][o] <= rows[tgt_sel][o];
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (step_done) begin
            for (int p = 0; p < NPAGES; p++)
              for (int o = 0; o < BUF_BYTES; o++) mem[p][o] <= 8'hFF;
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R7: a cycle only begins right after a launch request
  assert_busy_after_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch_prog || launch_wipe));

  // R9: a guarded program target never starts a cycle
  assert_guarded_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_prog && !busy && guard_page) |=> !busy);

  // R8: requests during a cycle do not retarget it
  assert_busy_holds_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (launch_prog || launch_wipe)) |=> $stable(tgt_page));

  // R7: a cycle ends only when its final phase count runs out
  assert_end_on_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(step_done));

endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine #(
  parameter int                NPAGES       = 4,
  parameter int                BUF_BYTES    = 12,
  parameter int                BINARY_PAGES = 0,
  parameter int                ERASE_CYC    = 20,
  parameter int                PROG_CYC     = 30,
  parameter int                WIPE_CYC     = 40,
  parameter logic [NPAGES-1:0] PROT_MASK    = NPAGES'(2)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         spi_sclk,
  input  logic                         spi_cs_n,
  input  logic                         spi_mosi,
  input  logic                         wp,
  output logic                         ready,
  input  logic [$clog2(NPAGES)-1:0]    peek_page,
  input  logic [$clog2(BUF_BYTES)-1:0] peek_ofs,
  output logic [7:0]                   peek_byte
);
  localparam int PTR_W = $clog2(BUF_BYTES);
  localparam int PG_W  = $clog2(NPAGES);

  logic             rx_valid;
  logic [7:0]       rx_byte;
  logic             frame_start;
  logic             frame_end;
  logic             frame_aligned;
  logic             busy;
  logic             buf_we;
  logic             buf_sel;
  logic [PTR_W-1:0] buf_ptr;
  logic [7:0]       buf_wdata;
  logic             launch_prog;
  logic             launch_wipe;
  logic [PG_W-1:0]  prog_page;
  logic             prog_sel;
  logic [7:0]       rows [2][BUF_BYTES];

  assign ready = ~busy;

  ffe_spi_rx u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclk          (spi_sclk),
    .cs_n          (spi_cs_n),
    .mosi          (spi_mosi),
    .byte_valid    (rx_valid),
    .byte_data     (rx_byte),
    .frame_start   (frame_start),
    .frame_end     (frame_end),
    .frame_aligned (frame_aligned)
  );

  ffe_cmd_decode #(
    .BUF_BYTES    (BUF_BYTES),
    .NPAGES       (NPAGES),
    .BINARY_PAGES (BINARY_PAGES)
  ) u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_valid    (rx_valid),
    .byte_data     (rx_byte),
    .frame_start   (frame_start),
    .frame_end     (frame_end),
    .frame_aligned (frame_aligned),
    .busy          (busy),
    .buf_we        (buf_we),
    .buf_sel       (buf_sel),
    .buf_ptr       (buf_ptr),
    .buf_wdata     (buf_wdata),
    .launch_prog   (launch_prog),
    .launch_wipe   (launch_wipe),
    .prog_page     (prog_page),
    .prog_sel      (prog_sel)
  );

  ffe_page_buffers #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (buf_we),
    .sel   (buf_sel),
    .ptr   (buf_ptr),
    .wdata (buf_wdata),
    .rows  (rows)
  );

  ffe_cycle_seq #(
    .NPAGES    (NPAGES),
    .BUF_BYTES (BUF_BYTES),
    .ERASE_CYC (ERASE_CYC),
    .PROG_CYC  (PROG_CYC),
    .WIPE_CYC  (WIPE_CYC),
    .PROT_MASK (PROT_MASK)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_prog (launch_prog),
    .launch_wipe (launch_wipe),
    .prog_page   (prog_page),
    .prog_sel    (prog_sel),
    .rows        (rows),
    .wp          (wp),
    .peek_page   (peek_page),
    .peek_ofs    (peek_ofs),
    .busy        (busy),
    .peek_byte   (peek_byte)
  );

  // R8: no buffer write lands while a cycle is running
  assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_we);

endmodule

// File: tb/sim_flash_prog_engine.sv
module sim_flash_prog_engine;
  localparam int NP = 4;
  localparam int BB = 12;
  localparam int EC = 20;
  localparam int PC = 30;
  localparam int WC = 40;
  localparam logic [NP-1:0] PM = 4'b0010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       wp = 1'b0;
  logic       ready;
  logic [1:0] peek_page = 2'd0;
  logic [3:0] peek_ofs = 4'd0;
  logic [7:0] peek_byte;

  always #2 clk = ~clk;

  flash_prog_engine #(
    .NPAGES(NP), .BUF_BYTES(BB), .BINARY_PAGES(0),
    .ERASE_CYC(EC), .PROG_CYC(PC), .WIPE_CYC(WC), .PROT_MASK(PM)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .wp(wp), .ready(ready), .peek_page(peek_page), .peek_ofs(peek_ofs),
    .peek_byte(peek_byte)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference timing model: request -> staged -> busy countdown
  int model_left = 0;
  int stage_len = 0;
  int req_len = 0;

  int ref_mem [NP][BB];
  int ref_buf [2][BB];
  bit pend_v = 0;
  bit pend_wipe = 0;
  int pend_page = 0;
  int pend_sel = 0;

  always @(posedge clk) begin
    if (model_left > 0) model_left--;
    if (stage_len > 0) model_left = stage_len;
    stage_len = req_len;
    req_len = 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R7: ready compared against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done)
      check(ready === (model_left == 0), "R7 ready", int'(ready), int'(model_left == 0));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      tick(2);
      sclk = 1'b1;
      tick(2);
      sclk = 1'b0;
    end
  endtask

  function automatic bit model_busy();
    return (model_left > 0) || (stage_len > 0) || (req_len > 0);
  endfunction

  task automatic wait_idle();
    while (model_busy()) tick(1);
    tick(1);
    if (pend_v) begin
      for (int p = 0; p < NP; p++)
        for (int o = 0; o < BB; o++)
          if (pend_wipe) ref_mem[p][o] = 8'hFF;
          else if (p == pend_page) ref_mem[p][o] = ref_buf[pend_sel][o];
      pend_v = 0;
    end
  endtask

  task automatic check_page(input int p, input string req);
    for (int o = 0; o < BB; o++) begin
      tick(1);
      peek_page = 2'(p);
      peek_ofs = 4'(o);
      #1;
      check(peek_byte == 8'(ref_mem[p][o]), req, int'(peek_byte), ref_mem[p][o]);
    end
  endtask

  // behavioural frame model, then drive the frame
  task automatic run_cmd(input logic [7:0] q[$], input int tail, input bit nowait);
    bit vd;
    bit isprog;
    bit iswipe;
    bit go_prog;
    bit go_wipe;
    int pg;
    int ptr;
    int sel;
    tick(1);
    vd = model_busy();
    isprog = (q.size() >= 1) && (q[0] == 8'h82 || q[0] == 8'h85);
    sel = (q.size() >= 1 && q[0] == 8'h85) ? 1 : 0;
    pg = 0;
    if (isprog && q.size() >= 4) begin
      pg = ((int'(q[1]) << 5) | (int'(q[2]) >> 3)) % NP;          // R5 bits 23:11
      ptr = ((int'(q[2] & 8'h07) << 8) | int'(q[3])) % BB;      // R5 bits 10:0
      if (!vd)
        for (int i = 4; i < q.size(); i++) begin
          ref_buf[sel][ptr] = q[i];
          ptr = (ptr + 1) % BB;                                  // R6 wrap
        end
    end
    iswipe = (q.size() == 4) && q[0] == 8'hC7 && q[1] == 8'h94 && q[2] == 8'h80 && q[3] == 8'h9A;
    go_prog = !vd && tail == 0 && isprog && q.size() >= 4 && !(wp && PM[pg]);
    go_wipe = !vd && tail == 0 && iswipe && !(wp && (PM != 0));
    cs_n = 1'b0;
    tick(2);
    foreach (q[i]) send_bits(q[i], 8);
    if (tail > 0) send_bits(8'hFF, tail);
    tick(2);
    cs_n = 1'b1;
    if (go_prog || go_wipe) begin
      req_len = go_prog ? EC + PC : WC;
      pend_v = 1;
      pend_wipe = go_wipe;
      pend_page = pg;
      pend_sel = sel;
    end
    tick(2);
    if (go_prog && !nowait) begin
      while (model_left != PC) tick(1);
      peek_page = 2'(pg);
      peek_ofs = 4'd0;
      #1;
      check(peek_byte == 8'hFF, "R7 erase phase", int'(peek_byte), 8'hFF);
    end
    if (!nowait) wait_idle();
  endtask

  task automatic prog_cmd(input logic [7:0] opc, input int pf, input int of, input int n,
                          input int seed, input int tail, input bit nowait);
    logic [7:0] q[$];
    logic [23:0] a;
    a = 24'((pf << 11) | of);
    q.push_back(opc);
    q.push_back(a[23:16]);
    q.push_back(a[15:8]);
    q.push_back(a[7:0]);
    for (int i = 0; i < n; i++) q.push_back(8'(seed + i * 7));
    run_cmd(q, tail, nowait);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) for (int o = 0; o < BB; o++) ref_mem[p][o] = 0;
    for (int b = 0; b < 2; b++) for (int o = 0; o < BB; o++) ref_buf[b][o] = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check(ready == 1'b1, "R7 reset ready", int'(ready), 1);
    for (int p = 0; p < NP; p++) check_page(p, "R10 reset array");

    // R3 buffer 0, R5 start 0
    prog_cmd(8'h82, 2, 0, 5, 8'h10, 0, 0);
    check_page(2, "R3 buffer0 program");
    // R6 wrap through buffer 1
    prog_cmd(8'h85, 3, 10, 5, 8'h40, 0, 0);
    check_page(3, "R6 wrap");
    // R5 fields taken modulo
    prog_cmd(8'h82, 6, 13, 3, 8'h70, 0, 0);
    check_page(2, "R5 modulo fields");
    // R2 wipe
    run_cmd('{8'hC7, 8'h94, 8'h80, 8'h9A}, 0, 0);
    for (int p = 0; p < NP; p++) check_page(p, "R2 wipe");
    prog_cmd(8'h82, 0, 4, 4, 8'h21, 0, 0);
    run_cmd('{8'hC7, 8'h94, 8'h80, 8'h9B}, 0, 0);
    run_cmd('{8'hC7, 8'h94, 8'h80, 8'h9A, 8'h00}, 0, 0);
    check_page(0, "R2 bad key");
    // R3 unknown opcode
    run_cmd('{8'h55, 8'h00, 8'h00, 8'h00, 8'h11, 8'h22}, 0, 0);
    for (int p = 0; p < NP; p++) check_page(p, "R3 unknown opcode");
    // R1 mid-byte abort, R4 short address
    prog_cmd(8'h82, 1, 0, 3, 8'h33, 4, 0);
    check_page(1, "R1 abort");
    run_cmd('{8'h85, 8'h00, 8'h18}, 0, 0);
    check_page(3, "R4 short address");
    // R8 command during busy
    prog_cmd(8'h82, 0, 0, 2, 8'h5A, 0, 1);
    prog_cmd(8'h85, 0, 0, 6, 8'hA0, 0, 0);
    check_page(0, "R8 busy ignore array");
    prog_cmd(8'h85, 3, 0, 0, 8'h00, 0, 0);
    check_page(3, "R8 busy ignore buffer");
    // R9 write protect
    wp = 1'b1;
    prog_cmd(8'h82, 1, 0, 2, 8'h66, 0, 0);
    check_page(1, "R9 guarded page");
    prog_cmd(8'h82, 0, 5, 2, 8'h77, 0, 0);
    check_page(0, "R9 unguarded page");
    run_cmd('{8'hC7, 8'h94, 8'h80, 8'h9A}, 0, 0);
    check_page(0, "R9 wipe refused");
    wp = 1'b0;
    prog_cmd(8'h85, 1, 2, 3, 8'h88, 0, 1);
    tick(5);
    wp = 1'b1;
    wait_idle();
    check_page(1, "R9 late protect");
    prog_cmd(8'h82, 1, 0, 1, 8'h99, 0, 0);
    check_page(1, "R9 protect after cycle");
    wp = 1'b0;

    tick(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule